// File: doc/BRIEF.md
# Fine-Grained Multithread Issue Scheduler

This block decides, on every clock cycle, which of several hardware threads may send one instruction into a single shared integer pipeline. Each thread presents a request level, a parked level, and a pair of pulses that open and close a long-latency stall. A thread is eligible when it requests, is not parked and is not stalled. The grant rotates round-robin among eligible threads. A parked or stalled thread drops out of the rotation, and its cycles go to the remaining ready threads, which then issue more often than once per round.

The grant is combinational from the current inputs and the registered state, so the pipeline sees it in the same cycle. Stall state and the rotation pointer are registered. The core is reported idle when no thread could issue even if it requested, meaning every thread is parked or stalled.

Top module: `fgmt_sched`

## Requirements
- R1: At most one bit of `grant_o` is set; `grant_valid_o` is 1 exactly when one bit is set, and `grant_idx_o` then holds that bit's index.
- R2: A grant goes only to a thread whose `req_i` bit is 1, whose `park_i` bit is 0 and which is not stalled.
- R3: The search for a grant starts at the thread numbered one above the last granted thread and wraps from the highest thread to thread 0. With all four threads eligible, grants run 0,1,2,3,0,...
- R4: A parked thread never receives a grant. Its cycles go to the next eligible thread in rotation, so that thread can be granted more than once in four cycles.
- R5: A stall-begin pulse in cycle t makes the thread ineligible from cycle t+1 until a stall-end pulse. A stall-end pulse in cycle t makes it eligible again from cycle t+1.
- R6: When stall-begin and stall-end for one thread pulse in the same cycle, stall-end wins and the thread stays eligible in the next cycle.
- R7: `core_idle_o` is 1 exactly when every thread is parked or stalled. While it is 1, `grant_valid_o` is 0.
- R8: After reset no thread is stalled and the pointer is at thread 0, so the first grant with all threads eligible goes to thread 0.
- R9: A thread that stays eligible is granted within four cycles; it is never passed over for four cycles in a row.
- R10: A cycle without a grant leaves the rotation pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_THREADS | Thread has an instruction to issue |
| park_i | input | NUM_THREADS | Thread is parked (idle) |
| stall_begin_i | input | NUM_THREADS | Pulse: long-latency stall starts |
| stall_end_i | input | NUM_THREADS | Pulse: stall resolved |
| grant_o | output | NUM_THREADS | One-hot issue grant |
| grant_idx_o | output | IDX_W | Index of granted thread |
| grant_valid_o | output | 1 | A thread issues this cycle |
| core_idle_o | output | 1 | All threads parked or stalled |

## Verification
The bench targets the wrap of the rotation from thread 3 to thread 0. A pointer that restarts at 0 on every search would starve the higher threads and break the fairness bound. It also drives same-cycle stall-begin/stall-end pulses: a design that gives priority to the set would lose the thread until a later end pulse. Idle stretches with no requests check that the pointer holds its position rather than drifting. Idle cases with parked and stalled threads mixed together check that `core_idle_o` ignores missing requests and counts only unavailable threads.

// File: rtl/fgmt_sched_pkg.sv
`timescale 1ns/1ps
package fgmt_sched_pkg;

  typedef enum logic [1:0] {
    TH_READY   = 2'd0,
    TH_NOREQ   = 2'd1,
    TH_PARKED  = 2'd2,
    TH_STALLED = 2'd3
  } th_state_e;

endpackage

// File: rtl/fgmt_thread_slot.sv
`timescale 1ns/1ps
module fgmt_thread_slot
  import fgmt_sched_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic park_i,
  input  logic stall_begin_i,
  input  logic stall_end_i,
  output logic eligible_o,
  output logic available_o
);

  logic      stalled_q;
  th_state_e state;

  // end pulse overrides begin pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            stalled_q <= 1'b0;
    else if (stall_end_i)   stalled_q <= 1'b0;
    else if (stall_begin_i) stalled_q <= 1'b1;
  end

  always_comb begin
    if (park_i)         state = TH_PARKED;
    else if (stalled_q) state = TH_STALLED;
    else if (!req_i)    state = TH_NOREQ;
    else                state = TH_READY;
  end

  assign eligible_o  = (state == TH_READY);
  assign available_o = (state == TH_READY) || (state == TH_NOREQ);

  assert_stall_end_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_end_i |=> !stalled_q);

  assert_stall_enters_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_begin_i && !stall_end_i) |=> (stalled_q && !eligible_o));

  assert_stall_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stalled_q && !stall_end_i) |=> stalled_q);

endmodule

// File: rtl/fgmt_rr_pick.sv
`timescale 1ns/1ps
module fgmt_rr_pick #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned IDX_W       = 2
) (
  input  logic [NUM_THREADS-1:0] elig_i,
  input  logic [IDX_W-1:0]       start_i,
  output logic [NUM_THREADS-1:0] grant_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic                   valid_o
);

  localparam int unsigned SUM_W = IDX_W + 1;

  always_comb begin
    logic [SUM_W-1:0] j;
    grant_o = '0;
    idx_o   = '0;
    valid_o = 1'b0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      j = {1'b0, start_i} + SUM_W'(k);
      if (j >= SUM_W'(NUM_THREADS)) j = j - SUM_W'(NUM_THREADS);
      if (!valid_o && elig_i[j[IDX_W-1:0]]) begin
        valid_o                  = 1'b1;
        grant_o[j[IDX_W-1:0]]    = 1'b1;
        idx_o                    = j[IDX_W-1:0];
      end
    end
  end

endmodule

// File: rtl/fgmt_sched.sv
`timescale 1ns/1ps
module fgmt_sched
  import fgmt_sched_pkg::*;
#(
  parameter  int unsigned NUM_THREADS = 4,
  localparam int unsigned IDX_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_THREADS-1:0] req_i,
  input  logic [NUM_THREADS-1:0] park_i,
  input  logic [NUM_THREADS-1:0] stall_begin_i,
  input  logic [NUM_THREADS-1:0] stall_end_i,
  output logic [NUM_THREADS-1:0] grant_o,
  output logic [IDX_W-1:0]       grant_idx_o,
  output logic                   grant_valid_o,
  output logic                   core_idle_o
);

  localparam int unsigned CNT_W = $clog2(NUM_THREADS) + 1;

  logic [NUM_THREADS-1:0] elig;
  logic [NUM_THREADS-1:0] avail;
  logic [IDX_W-1:0]       ptr_q;
  logic                   started_q;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
    fgmt_thread_slot i_slot (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .req_i         (req_i[t]),
      .park_i        (park_i[t]),
      .stall_begin_i (stall_begin_i[t]),
      .stall_end_i   (stall_end_i[t]),
      .eligible_o    (elig[t]),
      .available_o   (avail[t])
    );
  end

  fgmt_rr_pick #(
    .NUM_THREADS (NUM_THREADS),
    .IDX_W       (IDX_W)
  ) i_pick (
    .elig_i  (elig),
    .start_i (ptr_q),
    .grant_o (grant_o),
    .idx_o   (grant_idx_o),
    .valid_o (grant_valid_o)
  );

  assign core_idle_o = ~|avail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (grant_valid_o) begin
      ptr_q <= (grant_idx_o == IDX_W'(NUM_THREADS - 1)) ? '0 : grant_idx_o + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  // per-thread wait tracking, used by the fairness bound only
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_wait
    logic [CNT_W-1:0] wait_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  wait_q <= '0;
      else if (!elig[t] || grant_o[t]) wait_q <= '0;
      else if (wait_q != '1)        wait_q <= wait_q + 1'b1;
    end
    assert_wait_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wait_q < CNT_W'(NUM_THREADS));
  end

  assert_grant_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && (grant_valid_o == (grant_o != '0)));

  assert_grant_idx_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> grant_o[grant_idx_o]);

  assert_grant_eligible_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & (~req_i | park_i)) == '0);

  assert_parked_no_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & park_i) == '0);

  assert_rotate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $past(started_q) && $past(grant_valid_o) &&
     $countones($past(elig)) >= 2 && elig == $past(elig)) |-> grant_o != $past(grant_o));

  assert_idle_no_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_idle_o |-> !grant_valid_o);

  assert_ptr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && !grant_valid_o) |=> $stable(ptr_q));

endmodule

// File: tb/test_fgmt_sched.sv
`timescale 1ns/1ps
module test_fgmt_sched;

  localparam int NT = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NT-1:0] req_i = '0;
  logic [NT-1:0] park_i = '0;
  logic [NT-1:0] stall_begin_i = '0;
  logic [NT-1:0] stall_end_i = '0;
  logic [NT-1:0] grant_o;
  logic [1:0]    grant_idx_o;
  logic          grant_valid_o;
  logic          core_idle_o;

  int checks = 0;
  int errors = 0;

  // reference state
  int ptr = 0;
  bit stl [NT];
  int wait_cnt [NT];

  always #2.5 clk_i = ~clk_i;

  fgmt_sched #(.NUM_THREADS(NT)) i_fgmt_sched (
    .clk_i, .rst_ni, .req_i, .park_i, .stall_begin_i, .stall_end_i,
    .grant_o, .grant_idx_o, .grant_valid_o, .core_idle_o
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // compare one cycle against the model, then advance model and clock
  task automatic step(input string tag);
    bit elig [NT];
    bit any_avail;
    int exp_idx;
    bit exp_valid;
    #1;
    any_avail = 0;
    for (int i = 0; i < NT; i++) begin
      elig[i] = req_i[i] && !park_i[i] && !stl[i];
      if (!park_i[i] && !stl[i]) any_avail = 1;
    end
    exp_valid = 0;
    exp_idx = 0;
    for (int k = 0; k < NT; k++) begin
      int j;
      j = (ptr + k) % NT;
      if (!exp_valid && elig[j]) begin
        exp_valid = 1;
        exp_idx = j;
      end
    end
    chk(grant_valid_o === exp_valid, tag, "grant_valid", int'(grant_valid_o), int'(exp_valid));
    chk(grant_o === (exp_valid ? NT'(1 << exp_idx) : NT'(0)), tag, "grant",
        int'(grant_o), exp_valid ? (1 << exp_idx) : 0);
    chk($countones(grant_o) <= 1, "R1", "onehot", $countones(grant_o), 1);
    if (exp_valid)
      chk(int'(grant_idx_o) == exp_idx, "R1", "grant_idx", int'(grant_idx_o), exp_idx);
    chk(core_idle_o === !any_avail, "R7", "core_idle", int'(core_idle_o), int'(!any_avail));
    for (int i = 0; i < NT; i++) begin
      if (elig[i] && !(exp_valid && exp_idx == i)) wait_cnt[i]++;
      else wait_cnt[i] = 0;
      if (wait_cnt[i] > NT - 1)
        chk(0, "R9", "wait cycles", wait_cnt[i], NT - 1);
    end
    if (exp_valid) ptr = (exp_idx + 1) % NT;
    for (int i = 0; i < NT; i++) begin
      if (stall_end_i[i]) stl[i] = 0;
      else if (stall_begin_i[i]) stl[i] = 1;
    end
    @(negedge clk_i);
  endtask

  task automatic run(input int n, input string tag);
    for (int c = 0; c < n; c++) step(tag);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < NT; i++) begin stl[i] = 0; wait_cnt[i] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R8: reset state, then first grant to thread 0
    run(2, "R8");
    req_i = '1;
    step("R8");
    // R3: full rotation with wrap
    run(8, "R3");

    // R4: parked thread skipped, slot reassigned
    park_i = 4'b0100;
    run(6, "R4");
    park_i = 4'b1110;
    run(4, "R4");
    park_i = '0;

    // R5: stall thread 1 then release
    stall_begin_i = 4'b0010; step("R5");
    stall_begin_i = '0;      run(6, "R5");
    stall_end_i = 4'b0010;   step("R5");
    stall_end_i = '0;        run(5, "R5");

    // R6: simultaneous begin and end on thread 0
    req_i = 4'b0001;
    stall_begin_i = 4'b0001; stall_end_i = 4'b0001; step("R6");
    stall_begin_i = '0;      stall_end_i = '0;
    run(3, "R6");

    // R7: all unavailable through park and stall mix
    req_i = '1;
    stall_begin_i = 4'b1000; step("R7");
    stall_begin_i = '0;
    park_i = 4'b0111;
    run(4, "R7");
    stall_end_i = 4'b1000; step("R7");
    stall_end_i = '0; park_i = '0;
    run(3, "R7");

    // R10: no requests keeps pointer; rotation resumes from it
    req_i = 4'b0010; step("R10");
    req_i = '0;      run(5, "R10");
    req_i = '1;      run(5, "R10");

    // R2: pseudo-random stimulus against the model
    lfsr = 32'hACE1_2345;
    for (int c = 0; c < 600; c++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      req_i = lfsr[3:0] | lfsr[7:4];
      park_i = lfsr[11:8] & lfsr[15:12] & lfsr[19:16];
      stall_begin_i = lfsr[23:20] & lfsr[27:24] & lfsr[31:28];
      stall_end_i = lfsr[27:24] & ~lfsr[13:10];
      step("R2");
    end
    req_i = '0; park_i = '0; stall_begin_i = '0; stall_end_i = '0;
    run(2, "R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule